// File: doc/BRIEF.md
# Escalating Priority Arbiter for a Shared Memory Port

This block decides which of six requestor classes may use one shared memory port. The classes are two internal DMA channels (a configuration-bus channel and a memory-to-memory channel), the processor, slave DMA, block-oriented coherence and global coherence. Each class gets a 3-bit urgency level, where 0 is the most urgent. Some levels are fixed, some come from software registers and one comes from an external input. The requestor with the most urgent level wins. Equal levels resolve by a fixed index order. Global coherence overrides everything.

A starvation guard sits on every class except global coherence. A per-requestor counter records how many decisions the request has lost. Once that count reaches the class's 6-bit wait limit, the request competes at level 0. The memory-to-memory DMA channel can also borrow level 0 for a short time. This happens when it is stalled by contention while the configuration channel is also pending, and it lasts until its pending data phase completes.

The grant is registered and one-hot. A holder keeps the grant for as long as it holds its request. A new decision is made only in a cycle with no active holder.

Top module: `prio_escalate_arb`

## Requirements
- R1: `grant` is one-hot or zero, `grant_idx` gives the index of the set bit, and `grant_vld` is high exactly when a bit is set. A decision is made in a cycle where no granted requestor still requests. It goes to a requestor that was requesting in that cycle and appears on `grant` after the next clock edge. With no requests, `grant` returns to zero. After reset `grant` is zero.
- R2: While the granted requestor keeps its request high, `grant` does not change, whatever else requests.
- R3: A global coherence request (index 5) wins every decision.
- R4: Among indices 0..4 the lowest effective level wins. Equal levels go to the lowest index. The index order is 0 configuration DMA, 1 memory DMA, 2 processor, 3 slave DMA, 4 block coherence.
- R5: Index 0 always has base level 0. Index 4 always has base level 7.
- R6: The base level of index 1 is bits [31:29] of the register written with `cfg_sel`=4. It resets to 7.
- R7: The processor base level is bits [10:8] of the register written with `cfg_sel`=0 (reset 7). It is captured in the cycle the processor request rises. A write made while that request stays high has no effect on that request.
- R8: The slave DMA base level is `sdma_pri`, sampled in the decision cycle.
- R9: For indices 0..4, each decision a pending request loses adds one to its counter. The counter saturates at 63 and clears on a win or when the request drops. When the counter is at or above its class limit, the request competes at level 0.
- R10: A wait limit of 0 disables escalation for that class.
- R11: If indices 0 and 1 both request while `ch1_stall` is high, index 1 competes at level 0 from the next cycle until a `ch1_done` pulse. After that pulse it returns to its R6 level. `ch1_done` takes precedence over setting.
- R12: The wait limits are bits [5:0] of the registers written with `cfg_sel`. Selector 0 sets the processor limit, 1 the limit shared by indices 0 and 1, 2 the slave DMA limit, and 3 the block coherence limit. All limits reset to 0. A write lands at the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 6 | Request per class, index order per R3/R4 |
| sdma_pri | input | 3 | Slave DMA urgency level |
| ch1_stall | input | 1 | Memory DMA channel blocked by contention |
| ch1_done | input | 1 | Memory DMA pending data phase completed |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register selector |
| cfg_wdata | input | 32 | Register write data |
| grant | output | 6 | Registered one-hot grant |
| grant_idx | output | 3 | Index of the granted requestor |
| grant_vld | output | 1 | Some requestor holds the grant |

## Verification
The assertions take two things for granted about the inputs. The first is that a holder lowers its request to hand the port on. The second is that `ch1_done` only marks the end of a data phase that was actually borrowed. They also assume that no configuration write targets a selector above 4. The stimulus changes inputs only between clock edges. It writes only selectors 0 to 4, and it drops every request for a cycle before each new scenario. This means counters and captured levels start from known values. The sweep covers all 512 combinations of processor, memory DMA and slave DMA levels against block coherence, with escalation disabled.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
   localparam int NREQ   = 6;
   localparam int NLOW   = 5;
   localparam int IDX_W  = $clog2(NREQ);
   localparam int SEL_W  = 3;

   localparam int IX_CFGDMA = 0;
   localparam int IX_MEMDMA = 1;
   localparam int IX_CPU    = 2;
   localparam int IX_SDMA   = 3;
   localparam int IX_BCOH   = 4;
   localparam int IX_GCOH   = 5;

   typedef enum logic [SEL_W-1:0] {
      SEL_CPU  = 3'd0,
      SEL_IDMA = 3'd1,
      SEL_SDMA = 3'd2,
      SEL_BCOH = 3'd3,
      SEL_CH1  = 3'd4
   } cfg_sel_e;
endpackage

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
   import prio_arb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WAIT_W = 6,
   parameter int PRI_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [WAIT_W-1:0] cpu_wait,
   output logic [WAIT_W-1:0] idma_wait,
   output logic [WAIT_W-1:0] sdma_wait,
   output logic [WAIT_W-1:0] bcoh_wait,
   output logic [PRI_W-1:0]  cpu_pri,
   output logic [PRI_W-1:0]  ch1_pri
);
   localparam int CPU_PRI_LSB = 8;
   localparam int CH1_PRI_LSB = DATA_W - PRI_W;

   if (WAIT_W > CPU_PRI_LSB || CPU_PRI_LSB + PRI_W > CH1_PRI_LSB) begin : g_bad_layout
      $error("arb_cfg_regs: fields overlap for chosen widths");
   end

   logic unused_wdata;
   assign unused_wdata = ^{wdata[CH1_PRI_LSB-1:CPU_PRI_LSB+PRI_W],
                           wdata[CPU_PRI_LSB-1:WAIT_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_wait  <= '0;
         idma_wait <= '0;
         sdma_wait <= '0;
         bcoh_wait <= '0;
         cpu_pri   <= '1;
         ch1_pri   <= '1;
      end else if (we) begin
         case (sel)
            SEL_CPU: begin
               cpu_wait <= wdata[WAIT_W-1:0];
               cpu_pri  <= wdata[CPU_PRI_LSB +: PRI_W];
            end
            SEL_IDMA: idma_wait <= wdata[WAIT_W-1:0];
            SEL_SDMA: sdma_wait <= wdata[WAIT_W-1:0];
            SEL_BCOH: bcoh_wait <= wdata[WAIT_W-1:0];
            SEL_CH1:  ch1_pri   <= wdata[CH1_PRI_LSB +: PRI_W];
            default: ;
         endcase
      end
   end

   assert_cfg_cpu_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_CPU) |=> (cpu_wait == $past(wdata[WAIT_W-1:0])));
   assert_cfg_ch1_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == SEL_CH1) |=> (ch1_pri == $past(wdata[CH1_PRI_LSB +: PRI_W])));
endmodule

// File: rtl/arb_wait_ctr.sv
module arb_wait_ctr #(
   parameter int WAIT_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pending,
   input  logic              decide,
   input  logic              won,
   input  logic [WAIT_W-1:0] limit,
   output logic              escalate
);
   localparam logic [WAIT_W-1:0] CNT_MAX = '1;

   if (WAIT_W < 1) begin : g_bad_width
      $error("arb_wait_ctr: WAIT_W must be positive");
   end

   logic [WAIT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt <= '0;
      else if (!pending || won)            cnt <= '0;
      else if (decide && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
   end

   assign escalate = pending && (limit != '0) && (cnt >= limit);

   assert_ctr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      won |=> (cnt == '0));
   assert_ctr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && decide && !won && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
   parameter int NIN   = 5,
   parameter int PRI_W = 3
) (
   input  logic [NIN-1:0]            req,
   input  logic [NIN-1:0][PRI_W-1:0] pri,
   output logic [NIN-1:0]            win
);
   always_comb begin
      logic [PRI_W-1:0] best;
      logic             found;
      win   = '0;
      best  = '1;
      found = 1'b0;
      for (int i = 0; i < NIN; i++) begin
         if (req[i] && (!found || pri[i] < best)) begin
            win    = '0;
            win[i] = 1'b1;
            best   = pri[i];
            found  = 1'b1;
         end
      end
   end

   always_comb begin
      assert_pick_subset_R4: assert ((win & ~req) == '0);
   end
endmodule

// File: rtl/prio_escalate_arb.sv
module prio_escalate_arb
   import prio_arb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int WAIT_W = 6,
   parameter int PRI_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [5:0]        req,
   input  logic [2:0]        sdma_pri,
   input  logic              ch1_stall,
   input  logic              ch1_done,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   output logic [5:0]        grant,
   output logic [2:0]        grant_idx,
   output logic              grant_vld
);
   if (PRI_W != 3 || DATA_W != 32 || WAIT_W < 1 || NREQ != 6) begin : g_bad_cfg
      $error("prio_escalate_arb: unsupported parameter set");
   end

   logic [WAIT_W-1:0] cpu_wait, idma_wait, sdma_wait, bcoh_wait;
   logic [PRI_W-1:0]  cfg_cpu_pri, ch1_pri;

   arb_cfg_regs #(.DATA_W(DATA_W), .WAIT_W(WAIT_W), .PRI_W(PRI_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .cpu_wait(cpu_wait), .idma_wait(idma_wait), .sdma_wait(sdma_wait),
      .bcoh_wait(bcoh_wait), .cpu_pri(cfg_cpu_pri), .ch1_pri(ch1_pri));

   logic [NREQ-1:0] grant_q;
   logic            busy, decide;
   assign busy   = |(grant_q & req);
   assign decide = !busy && (|req);

   // processor level captured at request start
   logic             cpu_seen_q;
   logic [PRI_W-1:0] cpu_pri_q, cpu_base;
   logic             cpu_start;
   assign cpu_start = req[IX_CPU] && !cpu_seen_q;
   assign cpu_base  = cpu_start ? cfg_cpu_pri : cpu_pri_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_seen_q <= 1'b0;
         cpu_pri_q  <= '1;
      end else begin
         cpu_seen_q <= req[IX_CPU];
         if (cpu_start) cpu_pri_q <= cfg_cpu_pri;
      end
   end

   // borrowed top level for the memory DMA channel
   logic inh_q;
   always_ff @(posedge clk) begin
      if (!rst_n)        inh_q <= 1'b0;
      else if (ch1_done) inh_q <= 1'b0;
      else if (req[IX_CFGDMA] && req[IX_MEMDMA] && ch1_stall) inh_q <= 1'b1;
   end

   logic [NLOW-1:0][PRI_W-1:0] base_pri, eff_pri;
   logic [NLOW-1:0]            esc, win_lo;
   logic [NREQ-1:0]            win_all;

   assign base_pri[IX_CFGDMA] = '0;
   assign base_pri[IX_MEMDMA] = inh_q ? '0 : ch1_pri;
   assign base_pri[IX_CPU]    = cpu_base;
   assign base_pri[IX_SDMA]   = sdma_pri;
   assign base_pri[IX_BCOH]   = '1;

   assign win_all = req[IX_GCOH] ? NREQ'(1 << IX_GCOH) : {1'b0, win_lo};

   for (genvar i = 0; i < NLOW; i++) begin : g_ctr
      logic [WAIT_W-1:0] lim;
      if (i == IX_CFGDMA || i == IX_MEMDMA) begin : g_idma
         assign lim = idma_wait;
      end else if (i == IX_CPU) begin : g_cpu
         assign lim = cpu_wait;
      end else if (i == IX_SDMA) begin : g_sdma
         assign lim = sdma_wait;
      end else begin : g_bcoh
         assign lim = bcoh_wait;
      end

      arb_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .pending(req[i]), .decide(decide),
         .won(decide && win_all[i]), .limit(lim), .escalate(esc[i]));

      assign eff_pri[i] = esc[i] ? '0 : base_pri[i];
   end

   arb_pick #(.NIN(NLOW), .PRI_W(PRI_W)) u_pick (
      .req(req[NLOW-1:0]), .pri(eff_pri), .win(win_lo));

   always_ff @(posedge clk) begin
      if (!rst_n)     grant_q <= '0;
      else if (!busy) grant_q <= win_all;
   end

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < NREQ; i++) begin
         if (grant_q[i]) grant_idx = IDX_W'(i);
      end
   end

   assign grant     = grant_q;
   assign grant_vld = |grant_q;

   assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_q));
   assert_grant_was_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ((grant_q & ~$past(req)) == '0));
   assert_grant_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (grant_q == $past(grant_q)));
   assert_global_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && req[IX_GCOH]) |=> grant_q[IX_GCOH]);
   assert_inherit_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (inh_q && !ch1_done) |=> inh_q);
endmodule

// File: tb/sim_prio_escalate_arb.sv
`timescale 1ns/1ps
module sim_prio_escalate_arb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  req;
   logic [2:0]  sdma_pri;
   logic        ch1_stall, ch1_done, cfg_we;
   logic [2:0]  cfg_sel;
   logic [31:0] cfg_wdata;
   logic [5:0]  grant;
   logic [2:0]  grant_idx;
   logic        grant_vld;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   prio_escalate_arb u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .sdma_pri(sdma_pri),
      .ch1_stall(ch1_stall), .ch1_done(ch1_done), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .grant(grant),
      .grant_idx(grant_idx), .grant_vld(grant_vld));

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] sel, input logic [31:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      cyc();
      cfg_we = 1'b0;
   endtask

   task automatic expect_grant(input string tag, input int idx);
      total++;
      if (grant !== 6'(1 << idx) || grant_idx !== 3'(idx) || grant_vld !== 1'b1) begin
         bad++;
         $display("FAIL %s: grant=%b idx=%0d vld=%b expected idx=%0d",
                  tag, grant, grant_idx, grant_vld, idx);
      end
   endtask

   task automatic expect_none(input string tag);
      total++;
      if (grant !== 6'b0 || grant_vld !== 1'b0) begin
         bad++;
         $display("FAIL %s: grant=%b vld=%b expected none", tag, grant, grant_vld);
      end
   endtask

   task automatic idle();
      req = '0; ch1_stall = 1'b0; ch1_done = 1'b0;
      cyc(); cyc();
   endtask

   function automatic int model_pick(input int c, input int p, input int s);
      int w = 4;
      int b = 7;
      if (s <= b) begin w = 3; b = s; end
      if (c <= b) begin w = 2; b = c; end
      if (p <= b) begin w = 1; b = p; end
      return w;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not end, got=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; req = '0; sdma_pri = 3'd7; ch1_stall = 1'b0; ch1_done = 1'b0;
      cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
      @(negedge clk); cyc(); cyc();
      rst_n = 1'b1;
      cyc();
      expect_none("R1 reset state");

      // R5: fixed top level of index 0 beats block coherence
      req = 6'b010001; cyc();
      expect_grant("R5 cfg dma over block coherence", 0);
      idle();
      expect_none("R1 grant clears when idle");

      // R5: block coherence alone still served
      req = 6'b010000; cyc();
      expect_grant("R5 block coherence alone", 4);
      idle();

      // R2 hold then R3 takeover
      req = 6'b000001; cyc();
      expect_grant("R2 holder granted", 0);
      req = 6'b111111; cyc();
      expect_grant("R2 holder kept while requesting", 0);
      cyc();
      expect_grant("R2 holder kept second cycle", 0);
      req = 6'b111110; cyc();
      expect_grant("R3 global coherence wins", 5);
      idle();

      // R4 ties at reset levels (all 7)
      req = 6'b010100; cyc();
      expect_grant("R4 tie processor before block coherence", 2);
      idle();
      req = 6'b000110; cyc();
      expect_grant("R4 tie memory dma before processor", 1);
      idle();

      // R4/R6/R7/R8 sweep over levels
      for (int c = 0; c < 8; c++) begin
         for (int p = 0; p < 8; p++) begin
            for (int s = 0; s < 8; s++) begin
               wr(3'd0, 32'(c) << 8);
               wr(3'd4, 32'(p) << 29);
               sdma_pri = 3'(s);
               req = 6'b011110; cyc();
               expect_grant($sformatf("R4 R6 R7 R8 sweep c=%0d p=%0d s=%0d", c, p, s),
                            model_pick(c, p, s));
               req = '0; cyc();
            end
         end
      end
      idle();

      // R7: level captured at request start
      wr(3'd0, 32'd1 << 8);
      req = 6'b000001; cyc();
      expect_grant("R7 blocker granted", 0);
      sdma_pri = 3'd2;
      req = 6'b001101; cyc();
      wr(3'd0, 32'd5 << 8);
      req = 6'b001100; cyc();
      expect_grant("R7 old level kept for pending request", 2);
      idle();
      req = 6'b001100; cyc();
      expect_grant("R7 new level used for new request", 3);
      idle();

      // R9 escalation, limit 2 on block coherence
      wr(3'd0, 32'd3 << 8);
      wr(3'd3, 32'd2);
      sdma_pri = 3'd3;
      req = 6'b011100; cyc();
      expect_grant("R9 first decision processor", 2);
      req = 6'b011000; cyc();
      expect_grant("R9 second decision slave dma", 3);
      req = 6'b011100; cyc();
      expect_grant("R2 slave dma holds", 3);
      req = 6'b010100; cyc();
      expect_grant("R9 escalated block coherence wins", 4);
      idle();

      // R10 limit 0 disables
      wr(3'd3, 32'd0);
      req = 6'b011100; cyc();
      expect_grant("R10 first decision processor", 2);
      req = 6'b011000; cyc();
      expect_grant("R10 second decision slave dma", 3);
      req = 6'b011100; cyc();
      req = 6'b010100; cyc();
      expect_grant("R10 no escalation processor wins", 2);
      idle();

      // R11 inheritance
      wr(3'd4, 32'd6 << 29);
      wr(3'd0, 32'd3 << 8);
      req = 6'b100000; cyc();
      expect_grant("R11 global holds", 5);
      req = 6'b100111; ch1_stall = 1'b1; cyc();
      ch1_stall = 1'b0;
      req = 6'b100110; cyc();
      req = 6'b000110; cyc();
      expect_grant("R11 memory dma borrows level 0", 1);
      ch1_done = 1'b1; cyc();
      ch1_done = 1'b0;
      req = '0; cyc(); cyc();
      req = 6'b000110; cyc();
      expect_grant("R11 level restored after done", 2);
      idle();

      // R12 reset-time limits are zero: repeated losses never escalate
      wr(3'd0, 32'd0);
      req = 6'b000101; cyc();
      expect_grant("R12 cfg dma first", 0);
      req = 6'b000100; cyc();
      expect_grant("R12 processor after handoff", 2);
      idle();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule